// File: doc/BRIEF.md
# Firmware Client Discovery Sequencer

This block is the host-side state machine that brings a transport link to a co-processor up and finds out which firmware clients live behind it. After a `go` pulse it sends a start command and waits for the reply. If the reply advertises a boot loader, the block first walks a three-step loader exchange. It then asks for the client map, a bitmap of firmware client ids. It walks that map from the lowest id upward and sends one properties query per set bit. Each query waits for its own reply before the next one goes out.

Every properties reply carries a client UUID and that client's largest message size. Both are stored in a small table indexed by client id, which the rest of the host reads through a combinational read port. When the last reply has been stored, the block raises a sticky link-ready flag and pulses a buffer-allocation request for one cycle. Every wait is guarded by a timeout that leads to a sticky error state. Replies that do not match the pending command are dropped and counted.

Commands leave on `req_cmd`/`req_id` with a one-cycle `req_valid` strobe. Replies arrive on `rsp_cmd`/`rsp_data` with a one-cycle `rsp_valid` strobe. A reply code is always its command code with bit 7 set.

Top module: `fwc_discovery`

## Requirements
- R1: After reset `req_valid`, `link_ready`, `dma_alloc` and `link_err` are 0, `unexp_cnt` is 0, and every table entry reads as not valid.
- R2: A `go` pulse in the idle state issues the start command (code 0x01) as a `req_valid` strobe lasting exactly one cycle. Each command is issued as such a single-cycle strobe.
- R3: A start reply (0x81) with `rsp_data[0]`=0 is followed by the client-map command (0x04) with `req_id`=0.
- R4: A start reply with `rsp_data[0]`=1 is followed by the loader commands 0x10, 0x11 and 0x12 in that order. Each of them waits for its reply (0x90, 0x91, 0x92), and the client-map command follows the last one.
- R5: The client-map reply (0x84) carries the bitmap in `rsp_data[N_CLIENTS-1:0]`. One properties command (0x05) is issued per set bit, in ascending id order, with the id on `req_id`. The next command goes out only after the reply to the current one.
- R6: A properties reply (0x85) stores `rsp_data[UUID_W-1:0]` as the UUID and `rsp_data[UUID_W+MAXLEN_W-1:UUID_W]` as the maximum message size for the pending id. Only the ids that were queried read as valid.
- R7: Two cycles after the reply for the last set bit is captured, `link_ready` becomes 1 and stays 1, and `dma_alloc` is 1 for exactly that first cycle. An all-zero bitmap leads to ready in the same way, with no properties command.
- R8: A reply whose code differs from the pending reply code, or any reply while nothing is pending, changes no state and no table entry. It increments `unexp_cnt`, which saturates at its maximum value.
- R9: If no matching reply arrives within TIMEOUT cycles of waiting, `link_err` becomes 1. The error state then issues no commands and ignores replies and `go` until reset.
- R10: Once `link_ready` is 1, `go` and all replies cause no further commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start discovery (taken in idle only) |
| req_valid | output | 1 | Command strobe |
| req_cmd | output | 8 | Command code |
| req_id | output | IDX_W | Client id for a properties command, else 0 |
| rsp_valid | input | 1 | Reply strobe |
| rsp_cmd | input | 8 | Reply code |
| rsp_data | input | PAY_W | Reply payload |
| link_ready | output | 1 | All clients discovered |
| dma_alloc | output | 1 | One-cycle buffer-allocation request |
| link_err | output | 1 | Sticky timeout error |
| unexp_cnt | output | UNEXP_W | Saturating count of unmatched replies |
| tbl_idx | input | IDX_W | Table read index |
| tbl_valid | output | 1 | Entry filled |
| tbl_uuid | output | UUID_W | Stored UUID |
| tbl_maxlen | output | MAXLEN_W | Stored maximum message size |

## Verification
The hardest situation to reach is a reply that arrives in the middle of a properties walk but carries the wrong code. That reply must leave both the pending id and the table untouched. The bench plays the firmware side. Just after the properties command for id 2 of a sparse map, it answers with a client-map reply code, then confirms that no command follows and that id 2 is still empty before it sends the proper reply. Counter saturation is reached by holding the reply strobe for several hundred cycles once the link is ready.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    localparam int CMD_W = 8;
    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_START    = 8'h01;
    localparam cmd_t CMD_MAP      = 8'h04;
    localparam cmd_t CMD_PROPS    = 8'h05;
    localparam cmd_t CMD_LD_QUERY = 8'h10;
    localparam cmd_t CMD_LD_FRAG  = 8'h11;
    localparam cmd_t CMD_LD_RUN   = 8'h12;
    localparam cmd_t RSP_FLAG     = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_SCAN, ST_READY, ST_ERR
    } state_t;

    typedef enum logic [2:0] {
        STEP_START, STEP_LD_QUERY, STEP_LD_FRAG, STEP_LD_RUN, STEP_MAP, STEP_PROPS
    } step_t;

    function automatic cmd_t step_cmd(step_t s);
        case (s)
            STEP_START:    return CMD_START;
            STEP_LD_QUERY: return CMD_LD_QUERY;
            STEP_LD_FRAG:  return CMD_LD_FRAG;
            STEP_LD_RUN:   return CMD_LD_RUN;
            STEP_MAP:      return CMD_MAP;
            default:       return CMD_PROPS;
        endcase
    endfunction

    function automatic cmd_t reply_of(cmd_t c);
        return c | RSP_FLAG;
    endfunction

    // Chain of the link bring-up steps that precede the map walk
    function automatic step_t chain_next(step_t s, logic loader_cap);
        case (s)
            STEP_START:    return loader_cap ? STEP_LD_QUERY : STEP_MAP;
            STEP_LD_QUERY: return STEP_LD_FRAG;
            STEP_LD_FRAG:  return STEP_LD_RUN;
            STEP_LD_RUN:   return STEP_MAP;
            default:       return s;
        endcase
    endfunction

endpackage

// File: rtl/fwc_timer.sv
module fwc_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + CW'(1);
    end

    // R9
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/fwc_pick.sv
module fwc_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     map,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    assign found = |map;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (map[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fwc_table.sv
module fwc_table #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int UW    = 32,
    parameter int LW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [UW-1:0]    wuuid,
    input  logic [LW-1:0]    wlen,
    input  logic [IDX_W-1:0] ridx,
    output logic             rvalid,
    output logic [UW-1:0]    ruuid,
    output logic [LW-1:0]    rlen
);
    logic [N-1:0]  vld_q;
    logic [UW-1:0] uuid_q [N];
    logic [LW-1:0] len_q  [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g]  <= 1'b0;
                uuid_q[g] <= '0;
                len_q[g]  <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                vld_q[g]  <= 1'b1;
                uuid_q[g] <= wuuid;
                len_q[g]  <= wlen;
            end
        end

        // R6
        entry_fill_chk: assert property (@(posedge clk) disable iff (rst)
            (we && widx == IDX_W'(g)) |=> (vld_q[g] && uuid_q[g] == $past(wuuid)));
    end

    always_comb begin
        rvalid = 1'b0;
        ruuid  = '0;
        rlen   = '0;
        if (int'(ridx) < N) begin
            rvalid = vld_q[ridx];
            ruuid  = uuid_q[ridx];
            rlen   = len_q[ridx];
        end
    end

endmodule

// File: rtl/fwc_discovery.sv
module fwc_discovery
    import fwc_pkg::*;
#(
    parameter int N_CLIENTS = 8,
    parameter int UUID_W    = 32,
    parameter int MAXLEN_W  = 16,
    parameter int TIMEOUT   = 64,
    parameter int UNEXP_W   = 8,
    localparam int IDX_W    = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1,
    localparam int PROP_W   = UUID_W + MAXLEN_W,
    localparam int PAY_W    = (N_CLIENTS > PROP_W) ? N_CLIENTS : PROP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    output logic                req_valid,
    output logic [7:0]          req_cmd,
    output logic [IDX_W-1:0]    req_id,
    input  logic                rsp_valid,
    input  logic [7:0]          rsp_cmd,
    input  logic [PAY_W-1:0]    rsp_data,
    output logic                link_ready,
    output logic                dma_alloc,
    output logic                link_err,
    output logic [UNEXP_W-1:0]  unexp_cnt,
    input  logic [IDX_W-1:0]    tbl_idx,
    output logic                tbl_valid,
    output logic [UUID_W-1:0]   tbl_uuid,
    output logic [MAXLEN_W-1:0] tbl_maxlen
);
    state_t                state_q, state_d;
    step_t                 step_q, step_d;
    logic [N_CLIENTS-1:0]  remain_q, remain_d;
    logic [IDX_W-1:0]      cur_q, cur_d;
    logic                  dma_q;
    logic [UNEXP_W-1:0]    unexp_q;

    cmd_t                  exp_rsp;
    logic                  in_wait, accept, expired, pick_found, tbl_we;
    logic [IDX_W-1:0]      pick_idx;

    assign exp_rsp = reply_of(step_cmd(step_q));
    assign in_wait = (state_q == ST_WAIT);
    assign accept  = in_wait && rsp_valid && (rsp_cmd == exp_rsp);
    assign tbl_we  = accept && (step_q == STEP_PROPS);

    fwc_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (state_q == ST_ISSUE),
        .run     (in_wait),
        .expired (expired)
    );

    fwc_pick #(.N(N_CLIENTS), .IDX_W(IDX_W)) u_pick (
        .map   (remain_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    fwc_table #(.N(N_CLIENTS), .IDX_W(IDX_W), .UW(UUID_W), .LW(MAXLEN_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .widx   (cur_q),
        .wuuid  (rsp_data[UUID_W-1:0]),
        .wlen   (rsp_data[PROP_W-1:UUID_W]),
        .ridx   (tbl_idx),
        .rvalid (tbl_valid),
        .ruuid  (tbl_uuid),
        .rlen   (tbl_maxlen)
    );

    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        remain_d = remain_q;
        cur_d    = cur_q;
        case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_ISSUE;
                    step_d  = STEP_START;
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (accept) begin
                    case (step_q)
                        STEP_MAP: begin
                            remain_d = rsp_data[N_CLIENTS-1:0];
                            state_d  = ST_SCAN;
                        end
                        STEP_PROPS: begin
                            remain_d[cur_q] = 1'b0;
                            state_d         = ST_SCAN;
                        end
                        default: begin
                            step_d  = chain_next(step_q, rsp_data[0]);
                            state_d = ST_ISSUE;
                        end
                    endcase
                end else if (expired) begin
                    state_d = ST_ERR;
                end
            end
            ST_SCAN: begin
                if (pick_found) begin
                    cur_d   = pick_idx;
                    step_d  = STEP_PROPS;
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_READY;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            step_q   <= STEP_START;
            remain_q <= '0;
            cur_q    <= '0;
            dma_q    <= 1'b0;
            unexp_q  <= '0;
        end else begin
            state_q  <= state_d;
            step_q   <= step_d;
            remain_q <= remain_d;
            cur_q    <= cur_d;
            dma_q    <= (state_q == ST_SCAN) && !pick_found;
            if (rsp_valid && !accept && unexp_q != '1)
                unexp_q <= unexp_q + UNEXP_W'(1);
        end
    end

    assign req_valid  = (state_q == ST_ISSUE);
    assign req_cmd    = req_valid ? step_cmd(step_q) : '0;
    assign req_id     = (req_valid && step_q == STEP_PROPS) ? cur_q : '0;
    assign link_ready = (state_q == ST_READY);
    assign link_err   = (state_q == ST_ERR);
    assign dma_alloc  = dma_q;
    assign unexp_cnt  = unexp_q;

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R7
    dma_in_ready_chk: assert property (@(posedge clk) disable iff (rst)
        dma_alloc |-> link_ready);

    // R7
    dma_single_chk: assert property (@(posedge clk) disable iff (rst)
        dma_alloc |=> !dma_alloc);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        link_err |=> (link_err && !req_valid));

    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        link_ready |=> (link_ready && !req_valid));

    // R6
    store_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> (rsp_valid && rsp_cmd == reply_of(CMD_PROPS)));

    // R8
    unexp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cmd != exp_rsp && unexp_cnt != '1)
            |=> (unexp_cnt == $past(unexp_cnt) + UNEXP_W'(1)));

endmodule

// File: tb/fwc_discovery_tb.sv
module fwc_discovery_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int UW  = 32;
    localparam int LW  = 16;
    localparam int TO  = 32;
    localparam int UNW = 8;
    localparam int PW  = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0;
    logic          req_valid;
    logic [7:0]    req_cmd;
    logic [2:0]    req_id;
    logic          rsp_valid = 1'b0;
    logic [7:0]    rsp_cmd = '0;
    logic [PW-1:0] rsp_data = '0;
    logic          link_ready, dma_alloc, link_err;
    logic [UNW-1:0] unexp_cnt;
    logic [2:0]    tbl_idx = '0;
    logic          tbl_valid;
    logic [UW-1:0] tbl_uuid;
    logic [LW-1:0] tbl_maxlen;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwc_discovery #(.N_CLIENTS(N), .UUID_W(UW), .MAXLEN_W(LW), .TIMEOUT(TO), .UNEXP_W(UNW)) u_dut (
        .clk(clk), .rst(rst), .go(go),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_data(rsp_data),
        .link_ready(link_ready), .dma_alloc(dma_alloc), .link_err(link_err),
        .unexp_cnt(unexp_cnt), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_uuid(tbl_uuid), .tbl_maxlen(tbl_maxlen)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; go = 1'b0; rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_go();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    // Waits for a command strobe, checks it, and returns one cycle later
    task automatic expect_req(input logic [7:0] cmd, input logic [2:0] id, input string tag);
        int n = 0;
        while (req_valid !== 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(req_valid === 1'b1, {tag, " strobe"}, 64'(req_valid), 1);
        chk(req_cmd == cmd, {tag, " code"}, 64'(req_cmd), 64'(cmd));
        chk(req_id == id, {tag, " id"}, 64'(req_id), 64'(id));
        @(negedge clk);
        chk(req_valid === 1'b0, "R2 strobe single cycle", 64'(req_valid), 0);
    endtask

    task automatic send_rsp(input logic [7:0] cmd, input logic [PW-1:0] data);
        rsp_valid = 1'b1; rsp_cmd = cmd; rsp_data = data;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_data = '0;
    endtask

    task automatic no_req_for(input int cycles, input string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (req_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, 64'(seen), 0);
    endtask

    function automatic logic [PW-1:0] props_of(input int id);
        return {16'(16'h0100 + id), 32'(32'hC0DE_0000 + id)};
    endfunction

    task automatic t_reset();
        do_reset();
        tbl_idx = 3'd3;
        #1;
        chk(req_valid == 0 && link_ready == 0 && dma_alloc == 0 && link_err == 0, "R1 outputs idle",
            {req_valid, link_ready, dma_alloc, link_err}, 0);
        chk(unexp_cnt == 0, "R1 unexpected count", 64'(unexp_cnt), 0);
        chk(tbl_valid == 0, "R1 table empty", 64'(tbl_valid), 0);
    endtask

    task automatic t_walk();
        int ids[3] = '{2, 5, 7};
        do_reset();
        pulse_go();
        expect_req(8'h01, 3'd0, "R2 start command");
        send_rsp(8'h81, '0);
        expect_req(8'h04, 3'd0, "R3 map command");
        send_rsp(8'h84, 48'hA4);
        expect_req(8'h05, 3'd2, "R5 props id2");
        send_rsp(8'h84, 48'hFF);
        tbl_idx = 3'd2;
        no_req_for(3, "R8 wrong reply ignored");
        chk(tbl_valid == 0, "R8 wrong reply not stored", 64'(tbl_valid), 0);
        chk(unexp_cnt == 1, "R8 wrong reply counted", 64'(unexp_cnt), 1);
        send_rsp(8'h85, props_of(2));
        expect_req(8'h05, 3'd5, "R5 props id5");
        send_rsp(8'h85, props_of(5));
        expect_req(8'h05, 3'd7, "R5 props id7");
        chk(link_ready == 0, "R7 not ready before last reply", 64'(link_ready), 0);
        send_rsp(8'h85, props_of(7));
        @(negedge clk);
        chk(link_ready == 1, "R7 ready after last reply", 64'(link_ready), 1);
        chk(dma_alloc == 1, "R7 dma request raised", 64'(dma_alloc), 1);
        @(negedge clk);
        chk(dma_alloc == 0, "R7 dma request one cycle", 64'(dma_alloc), 0);
        foreach (ids[k]) begin
            tbl_idx = 3'(ids[k]);
            #1;
            chk(tbl_valid == 1, "R6 entry valid", 64'(tbl_valid), 1);
            chk(tbl_uuid == props_of(ids[k])[31:0], "R6 uuid", 64'(tbl_uuid), 64'(props_of(ids[k])[31:0]));
            chk(tbl_maxlen == props_of(ids[k])[47:32], "R6 max size", 64'(tbl_maxlen), 64'(props_of(ids[k])[47:32]));
        end
        tbl_idx = 3'd3;
        #1;
        chk(tbl_valid == 0, "R6 unqueried id empty", 64'(tbl_valid), 0);
        @(negedge clk);
        pulse_go();
        no_req_for(5, "R10 go ignored when ready");
        chk(link_ready == 1, "R10 ready holds", 64'(link_ready), 1);
        rsp_valid = 1'b1; rsp_cmd = 8'h85;
        repeat (300) @(negedge clk);
        rsp_valid = 1'b0;
        @(negedge clk);
        chk(unexp_cnt == 8'hFF, "R8 count saturates", 64'(unexp_cnt), 64'hFF);
        chk(link_ready == 1 && req_valid == 0, "R10 replies ignored when ready", {link_ready, req_valid}, 2);
    endtask

    task automatic t_loader();
        do_reset();
        pulse_go();
        expect_req(8'h01, 3'd0, "R4 start command");
        send_rsp(8'h81, 48'h1);
        expect_req(8'h10, 3'd0, "R4 loader query");
        send_rsp(8'h90, '0);
        expect_req(8'h11, 3'd0, "R4 loader fragment");
        send_rsp(8'h91, '0);
        expect_req(8'h12, 3'd0, "R4 loader run");
        send_rsp(8'h92, '0);
        expect_req(8'h04, 3'd0, "R4 map after loader");
        chk(unexp_cnt == 0, "R4 no unexpected replies", 64'(unexp_cnt), 0);
        send_rsp(8'h84, '0);
        chk(req_valid == 0, "R7 empty map no props", 64'(req_valid), 0);
        @(negedge clk);
        chk(link_ready == 1 && dma_alloc == 1, "R7 empty map ready", {link_ready, dma_alloc}, 3);
    endtask

    task automatic t_timeout();
        do_reset();
        pulse_go();
        expect_req(8'h01, 3'd0, "R9 start command");
        repeat (TO/2) @(negedge clk);
        chk(link_err == 0, "R9 no error before timeout", 64'(link_err), 0);
        repeat (TO) @(negedge clk);
        chk(link_err == 1, "R9 error after timeout", 64'(link_err), 1);
        send_rsp(8'h81, '0);
        no_req_for(3, "R9 late reply ignored");
        chk(unexp_cnt == 1, "R8 reply while nothing pending counted", 64'(unexp_cnt), 1);
        pulse_go();
        no_req_for(4, "R9 go ignored in error");
        chk(link_err == 1 && link_ready == 0, "R9 error sticky", {link_err, link_ready}, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_walk();
        t_loader();
        t_timeout();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule